// File: doc/BRIEF.md
# Per-Pin Function Mux Bank

This block is the register set and output routing for one bank of I/O pins. For every pin it decides who drives the pad. The pin can belong to a simple general-purpose controller, which supplies a data bit and an output-enable bit from its own registers. It can also belong to one of four internal peripheral slots, which supply their own output and output-enable signals. The block also holds the per-pin open-drain, pull-up and pull-down controls. It returns the live pad levels to software.

Software changes most control bits with mask writes. A word written to a "set" port raises every bit that is 1 in the mask. A word written to a "clear" port lowers every such bit. Bits that are 0 in the mask keep their value, so drivers never need a read-modify-write to change a single pin. Each control has a separate status word for reading it back. The peripheral choice is held in two plain read/write bit-planes: a low plane and a high plane. Together they form a two-bit slot code for each pin.

The bus is a single-cycle register port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

Top module: `pinfunc_bank`

## Requirements
- R1: Ownership register, reset all 1. A mask written at word offset 0 gives the masked pins to the GPIO controller (bit = 1). A mask written at offset 1 gives them to a peripheral (bit = 0). Offset 2 reads the ownership word.
- R2: Select planes are read/write at offset 3 (low plane) and offset 4 (high plane), reset 0. For a peripheral-owned pin i, the code {high,low} selects slot 0 to 3. `pad_out[i]` and the pre-open-drain enable then come from `per_out[k*NPINS+i]` and `per_oe[k*NPINS+i]` of slot k.
- R3: Output data is raised by a mask at offset 5 and lowered by a mask at offset 6. Offset 7 reads it, reset 0. Unmasked bits are unchanged. A GPIO-owned pin drives `pad_out` from its data bit.
- R4: Output enable is raised by a mask at offset 8 and lowered by a mask at offset 9. Offset 10 reads it, reset 0. A GPIO-owned pin with its enable bit at 0 has `pad_oe` at 0.
- R5: Offset 11 returns `pad_in` as it is now, whatever the ownership of each pin.
- R6: Open-drain is raised at offset 12, lowered at offset 13 and read at offset 14, reset 0. When a pin's open-drain bit is 1 and its selected drive value is 1, `pad_oe` is 0. When the drive value is 0, the enable passes through. `pad_out` is unaffected.
- R7: Pull-up is set at offset 15, cleared at 16 and read at 17, reset all 1. Pull-down is set at 18, cleared at 19 and read at 20, reset 0. `pad_pull_up` and `pad_pull_dn` follow these registers. Setting pull-down also clears pull-up for the masked pins.
- R8: After reset, every pin is GPIO-owned and an input with data 0. Pull-up is on, and pull-down and open-drain are off.
- R9: Set/clear offsets, status offsets and unmapped offsets (21 to 31) read 0 where they are not a status word. Writes to status or unmapped offsets change no register.
- R10: Registers change only on a write. Successive writes to a set port and its clear port on the same bit leave the value of the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Word offset of the port |
| bus_wdata | input | NPINS | Write data or pin mask |
| bus_rdata | output | NPINS | Combinational read data |
| per_out | input | 4*NPINS | Peripheral output values, slot k at bits [k*NPINS +: NPINS] |
| per_oe | input | 4*NPINS | Peripheral output enables, same layout |
| pad_in | input | NPINS | Live pad levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pull_up | output | NPINS | Pull-up enable per pin |
| pad_pull_dn | output | NPINS | Pull-down enable per pin |

## Verification
The pad routing is swept over ownership patterns (none, alternate nibbles, all) crossed with select-plane pairs: all-zero, each plane alone at all ones, both at all ones, and interleaved patterns that give every code on neighbouring pins. This is done with and without open-drain. The four peripheral slots carry distinct words, so a wrong slot, a swapped plane or a lost ownership bit shows as a different pad word. Mask writes use sparse, dense and single-bit masks to separate a masked update from a whole-word load. Back-to-back set and clear on the same bit show that the last write wins. Pull-down writes over an enabled pull-up show the forced clear.

// File: rtl/pinfunc_pkg.sv
// Shared constants and types for the per-pin function mux bank.
// Assumes a word-offset register map with a 5-bit address.
package pinfunc_pkg;

    localparam int ADDR_W = 5;
    localparam int NSLOTS = 4;
    localparam int CODE_W = $clog2(NSLOTS);

    // Word offsets of the bank's ports
    localparam logic [ADDR_W-1:0] OFS_OWN_SET  = 5'd0;
    localparam logic [ADDR_W-1:0] OFS_OWN_CLR  = 5'd1;
    localparam logic [ADDR_W-1:0] OFS_OWN_STAT = 5'd2;
    localparam logic [ADDR_W-1:0] OFS_SEL_LO   = 5'd3;
    localparam logic [ADDR_W-1:0] OFS_SEL_HI   = 5'd4;
    localparam logic [ADDR_W-1:0] OFS_DAT_SET  = 5'd5;
    localparam logic [ADDR_W-1:0] OFS_DAT_CLR  = 5'd6;
    localparam logic [ADDR_W-1:0] OFS_DAT_STAT = 5'd7;
    localparam logic [ADDR_W-1:0] OFS_OE_SET   = 5'd8;
    localparam logic [ADDR_W-1:0] OFS_OE_CLR   = 5'd9;
    localparam logic [ADDR_W-1:0] OFS_OE_STAT  = 5'd10;
    localparam logic [ADDR_W-1:0] OFS_PAD_STAT = 5'd11;
    localparam logic [ADDR_W-1:0] OFS_OD_SET   = 5'd12;
    localparam logic [ADDR_W-1:0] OFS_OD_CLR   = 5'd13;
    localparam logic [ADDR_W-1:0] OFS_OD_STAT  = 5'd14;
    localparam logic [ADDR_W-1:0] OFS_PU_SET   = 5'd15;
    localparam logic [ADDR_W-1:0] OFS_PU_CLR   = 5'd16;
    localparam logic [ADDR_W-1:0] OFS_PU_STAT  = 5'd17;
    localparam logic [ADDR_W-1:0] OFS_PD_SET   = 5'd18;
    localparam logic [ADDR_W-1:0] OFS_PD_CLR   = 5'd19;
    localparam logic [ADDR_W-1:0] OFS_PD_STAT  = 5'd20;

    // One-cycle write strobes produced by the decoder
    typedef struct packed {
        logic own_set;
        logic own_clr;
        logic sel_lo_wr;
        logic sel_hi_wr;
        logic dat_set;
        logic dat_clr;
        logic oe_set;
        logic oe_clr;
        logic od_set;
        logic od_clr;
        logic pu_set;
        logic pu_clr;
        logic pd_set;
        logic pd_clr;
    } wr_stb_t;

endpackage

// File: rtl/pinfunc_bus_dec.sv
// Write decoder: turns a bus write into one strobe for the addressed port.
// Assumes at most one write per cycle, so at most one strobe is high.
module pinfunc_bus_dec
    import pinfunc_pkg::*;
(
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output wr_stb_t           stb
);

    // Raise the strobe that matches the written offset
    always_comb begin
        stb = '0;
        if (we) begin
            case (addr)
                OFS_OWN_SET: stb.own_set   = 1'b1;
                OFS_OWN_CLR: stb.own_clr   = 1'b1;
                OFS_SEL_LO:  stb.sel_lo_wr = 1'b1;
                OFS_SEL_HI:  stb.sel_hi_wr = 1'b1;
                OFS_DAT_SET: stb.dat_set   = 1'b1;
                OFS_DAT_CLR: stb.dat_clr   = 1'b1;
                OFS_OE_SET:  stb.oe_set    = 1'b1;
                OFS_OE_CLR:  stb.oe_clr    = 1'b1;
                OFS_OD_SET:  stb.od_set    = 1'b1;
                OFS_OD_CLR:  stb.od_clr    = 1'b1;
                OFS_PU_SET:  stb.pu_set    = 1'b1;
                OFS_PU_CLR:  stb.pu_clr    = 1'b1;
                OFS_PD_SET:  stb.pd_set    = 1'b1;
                OFS_PD_CLR:  stb.pd_clr    = 1'b1;
                default:     stb           = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinfunc_mask_reg.sv
// One control word updated by mask: set ORs the mask in, clear removes it,
// load replaces the word. Assumes the strobes are mutually exclusive;
// load has priority, then set, then clear.
module pinfunc_mask_reg #(
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic         load_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);

    // Hold the word, update only the masked bits on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (load_stb) begin
            q <= mask;
        end else if (set_stb) begin
            q <= q | mask;
        end else if (clr_stb) begin
            q <= q & ~mask;
        end
    end

endmodule

// File: rtl/pinfunc_pin_route.sv
// Per-pin pad routing: picks the GPIO controller or one of the peripheral
// slots by ownership and the two-plane code, then applies open-drain.
// Assumes slot k's signals sit at bits [k*N +: N] of the flat inputs.
module pinfunc_pin_route
    import pinfunc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]        own,
    input  logic [N-1:0]        sel_lo,
    input  logic [N-1:0]        sel_hi,
    input  logic [N-1:0]        dat,
    input  logic [N-1:0]        oe,
    input  logic [N-1:0]        od,
    input  logic [NSLOTS*N-1:0] per_out,
    input  logic [NSLOTS*N-1:0] per_oe,
    output logic [N-1:0]        pad_out,
    output logic [N-1:0]        pad_oe
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [NSLOTS-1:0] slot_o;
        logic [NSLOTS-1:0] slot_e;
        logic [CODE_W-1:0] code;
        logic              drv;
        logic              en;

        // Gather this pin's bit from each peripheral slot
        for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
            assign slot_o[k] = per_out[k*N + i];
            assign slot_e[k] = per_oe[k*N + i];
        end

        assign code = {sel_hi[i], sel_lo[i]};

        // Choose the driver of this pin
        always_comb begin
            if (own[i]) begin
                drv = dat[i];
                en  = oe[i];
            end else begin
                drv = slot_o[code];
                en  = slot_e[code];
            end
        end

        // Open-drain releases the pad when the driven value is 1
        assign pad_out[i] = drv;
        assign pad_oe[i]  = en & ~(od[i] & drv);
    end

endmodule

// File: rtl/pinfunc_read_mux.sv
// Read-back multiplexer: returns the status word for the offset.
// Set/clear offsets and unmapped offsets return zero.
module pinfunc_read_mux
    import pinfunc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      own,
    input  logic [N-1:0]      sel_lo,
    input  logic [N-1:0]      sel_hi,
    input  logic [N-1:0]      dat,
    input  logic [N-1:0]      oe,
    input  logic [N-1:0]      pad_in,
    input  logic [N-1:0]      od,
    input  logic [N-1:0]      pu,
    input  logic [N-1:0]      pd,
    output logic [N-1:0]      rdata
);

    // Select the readable word addressed by the bus
    always_comb begin
        case (addr)
            OFS_OWN_STAT: rdata = own;
            OFS_SEL_LO:   rdata = sel_lo;
            OFS_SEL_HI:   rdata = sel_hi;
            OFS_DAT_STAT: rdata = dat;
            OFS_OE_STAT:  rdata = oe;
            OFS_PAD_STAT: rdata = pad_in;
            OFS_OD_STAT:  rdata = od;
            OFS_PU_STAT:  rdata = pu;
            OFS_PD_STAT:  rdata = pd;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinfunc_bank.sv
// Per-pin function mux bank top: mask-written control registers, two-plane
// peripheral select, pad routing with open-drain, pull controls and read-back.
// Assumes one bus write per cycle and a synchronous active-low reset.
module pinfunc_bank
    import pinfunc_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        bus_wdata,
    output logic [NPINS-1:0]        bus_rdata,
    input  logic [NSLOTS*NPINS-1:0] per_out,
    input  logic [NSLOTS*NPINS-1:0] per_oe,
    input  logic [NPINS-1:0]        pad_in,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS-1:0]        pad_pull_up,
    output logic [NPINS-1:0]        pad_pull_dn
);

    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};
    localparam logic [NPINS-1:0] ALL_ZERO = '0;

    wr_stb_t          stb;
    logic [NPINS-1:0] own_q;
    logic [NPINS-1:0] sel_lo_q;
    logic [NPINS-1:0] sel_hi_q;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] od_q;
    logic [NPINS-1:0] pu_q;
    logic [NPINS-1:0] pd_q;

    pinfunc_bus_dec u_dec (
        .we   (bus_we),
        .addr (bus_addr),
        .stb  (stb)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ONES)) u_own (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.own_set), .clr_stb(stb.own_clr),
        .load_stb(1'b0), .mask(bus_wdata), .q(own_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_sel_lo (
        .clk(clk), .rst_n(rst_n), .set_stb(1'b0), .clr_stb(1'b0),
        .load_stb(stb.sel_lo_wr), .mask(bus_wdata), .q(sel_lo_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_sel_hi (
        .clk(clk), .rst_n(rst_n), .set_stb(1'b0), .clr_stb(1'b0),
        .load_stb(stb.sel_hi_wr), .mask(bus_wdata), .q(sel_hi_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_dout (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.dat_set), .clr_stb(stb.dat_clr),
        .load_stb(1'b0), .mask(bus_wdata), .q(dout_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_oe (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.oe_set), .clr_stb(stb.oe_clr),
        .load_stb(1'b0), .mask(bus_wdata), .q(oe_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_od (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.od_set), .clr_stb(stb.od_clr),
        .load_stb(1'b0), .mask(bus_wdata), .q(od_q)
    );

    // A pull-down set also removes the pull-up on the same pins
    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ONES)) u_pu (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.pu_set),
        .clr_stb(stb.pu_clr | stb.pd_set),
        .load_stb(1'b0), .mask(bus_wdata), .q(pu_q)
    );

    pinfunc_mask_reg #(.W(NPINS), .RST_VAL(ALL_ZERO)) u_pd (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.pd_set), .clr_stb(stb.pd_clr),
        .load_stb(1'b0), .mask(bus_wdata), .q(pd_q)
    );

    pinfunc_pin_route #(.N(NPINS)) u_route (
        .own     (own_q),
        .sel_lo  (sel_lo_q),
        .sel_hi  (sel_hi_q),
        .dat     (dout_q),
        .oe      (oe_q),
        .od      (od_q),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    pinfunc_read_mux #(.N(NPINS)) u_rd (
        .addr   (bus_addr),
        .own    (own_q),
        .sel_lo (sel_lo_q),
        .sel_hi (sel_hi_q),
        .dat    (dout_q),
        .oe     (oe_q),
        .pad_in (pad_in),
        .od     (od_q),
        .pu     (pu_q),
        .pd     (pd_q),
        .rdata  (bus_rdata)
    );

    assign pad_pull_up = pu_q;
    assign pad_pull_dn = pd_q;

endmodule

// File: rtl/pinfunc_bank_chk.sv
// Property checker for the function mux bank, attached by bind.
// Watches bus writes, internal control words and pad outputs.
module pinfunc_bank_chk
    import pinfunc_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      own_q,
    input logic [N-1:0]      dout_q,
    input logic [N-1:0]      oe_q,
    input logic [N-1:0]      od_q,
    input logic [N-1:0]      pu_q,
    input logic [N-1:0]      pd_q,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_oe
);

    // R1
    own_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_OWN_CLR) |=> ((own_q & $past(bus_wdata)) == '0));

    // R3
    dat_set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DAT_SET) |=>
            (((dout_q & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((dout_q & ~$past(bus_wdata)) == ($past(dout_q) & ~$past(bus_wdata)))));

    // R3
    gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ dout_q) & own_q) == '0);

    // R4
    gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~oe_q & own_q) == '0);

    // R6
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & od_q) == '0);

    // R7
    pd_clears_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_PD_SET) |=>
            (((pu_q & $past(bus_wdata)) == '0) &&
             ((pd_q & $past(bus_wdata)) == $past(bus_wdata))));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(own_q) && $stable(dout_q) && $stable(oe_q) &&
                     $stable(od_q) && $stable(pu_q) && $stable(pd_q)));

endmodule

bind pinfunc_bank pinfunc_bank_chk #(.N(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .own_q     (own_q),
    .dout_q    (dout_q),
    .oe_q      (oe_q),
    .od_q      (od_q),
    .pu_q      (pu_q),
    .pd_q      (pd_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/tb_pinfunc_bank.sv
`timescale 1ns/1ps
// Self-checking bench: register model tracked from the requirements,
// pad routing swept over ownership, select-plane and open-drain patterns.
module tb_pinfunc_bank;
    import pinfunc_pkg::*;

    localparam int N = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [N-1:0]      bus_wdata;
    logic [N-1:0]      bus_rdata;
    logic [4*N-1:0]    per_out;
    logic [4*N-1:0]    per_oe;
    logic [N-1:0]      pad_in;
    logic [N-1:0]      pad_out;
    logic [N-1:0]      pad_oe;
    logic [N-1:0]      pad_pull_up;
    logic [N-1:0]      pad_pull_dn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the control words
    logic [N-1:0] m_own, m_lo, m_hi, m_dat, m_oe, m_od, m_pu, m_pd;

    always #2.5 clk = ~clk;

    pinfunc_bank #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_out(per_out),
        .per_oe(per_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One write cycle; the model follows the requirement text
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            OFS_OWN_SET: m_own = m_own | d;
            OFS_OWN_CLR: m_own = m_own & ~d;
            OFS_SEL_LO:  m_lo  = d;
            OFS_SEL_HI:  m_hi  = d;
            OFS_DAT_SET: m_dat = m_dat | d;
            OFS_DAT_CLR: m_dat = m_dat & ~d;
            OFS_OE_SET:  m_oe  = m_oe | d;
            OFS_OE_CLR:  m_oe  = m_oe & ~d;
            OFS_OD_SET:  m_od  = m_od | d;
            OFS_OD_CLR:  m_od  = m_od & ~d;
            OFS_PU_SET:  m_pu  = m_pu | d;
            OFS_PU_CLR:  m_pu  = m_pu & ~d;
            OFS_PD_SET:  begin m_pd = m_pd | d; m_pu = m_pu & ~d; end
            OFS_PD_CLR:  m_pd  = m_pd & ~d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [N-1:0] exp,
                          input string req);
        bus_addr = a;
        #1;
        chk(bus_rdata === exp, req, $sformatf("read offset %0d", a), bus_rdata, exp);
        @(negedge clk);
    endtask

    // Expected pad word from the model and slot inputs
    task automatic pads_chk(input string req);
        logic [N-1:0] eo, ee;
        for (int i = 0; i < N; i++) begin
            int  k;
            logic d, e;
            k = 2 * int'(m_hi[i]) + int'(m_lo[i]);
            d = m_own[i] ? m_dat[i] : per_out[k*N + i];
            e = m_own[i] ? m_oe[i]  : per_oe[k*N + i];
            eo[i] = d;
            ee[i] = e & ~(m_od[i] & d);
        end
        #1;
        chk(pad_out === eo, req, "pad_out", pad_out, eo);
        chk(pad_oe === ee, req, "pad_oe", pad_oe, ee);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] own_pats [3];
        logic [N-1:0] lo_pats  [5];
        logic [N-1:0] hi_pats  [5];
        own_pats = '{32'h0, 32'hF0F0_F0F0, 32'hFFFF_FFFF};
        lo_pats  = '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hAAAA_AAAA};
        hi_pats  = '{32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hCCCC_CCCC};

        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = 32'h1357_9BDF;
        per_out = {32'hA5A5_3C3C, 32'h5A5A_C3C3, 32'h0FF0_3C5A, 32'hF00F_A5C3};
        per_oe  = {32'h6969_9696, 32'hFFFF_0000, 32'h00FF_00FF, 32'hF0F0_0F0F};
        m_own = '1; m_lo = '0; m_hi = '0; m_dat = '0; m_oe = '0;
        m_od = '0; m_pu = '1; m_pd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        rd_chk(OFS_OWN_STAT, '1, "R8");
        rd_chk(OFS_OE_STAT,  '0, "R8");
        rd_chk(OFS_DAT_STAT, '0, "R8");
        rd_chk(OFS_PU_STAT,  '1, "R8");
        rd_chk(OFS_PD_STAT,  '0, "R8");
        rd_chk(OFS_OD_STAT,  '0, "R8");
        rd_chk(OFS_SEL_LO,   '0, "R8");
        #1;
        chk(pad_oe === '0, "R8", "pad_oe", pad_oe, '0);
        chk(pad_pull_up === '1, "R8", "pad_pull_up", pad_pull_up, '1);
        chk(pad_pull_dn === '0, "R8", "pad_pull_dn", pad_pull_dn, '0);
        @(negedge clk);

        // R3 masked data updates
        wr(OFS_DAT_SET, 32'h8000_0001); rd_chk(OFS_DAT_STAT, m_dat, "R3");
        wr(OFS_DAT_SET, 32'h00FF_0000); rd_chk(OFS_DAT_STAT, m_dat, "R3");
        wr(OFS_DAT_CLR, 32'h0010_0001); rd_chk(OFS_DAT_STAT, m_dat, "R3");
        wr(OFS_DAT_CLR, 32'h0);         rd_chk(OFS_DAT_STAT, m_dat, "R3");
        pads_chk("R3");

        // R4 output enable
        wr(OFS_OE_SET, 32'hFFFF_0000); rd_chk(OFS_OE_STAT, m_oe, "R4");
        wr(OFS_OE_CLR, 32'h0F00_0000); rd_chk(OFS_OE_STAT, m_oe, "R4");
        pads_chk("R4");

        // R1 ownership
        wr(OFS_OWN_CLR, 32'h0000_FFFF); rd_chk(OFS_OWN_STAT, m_own, "R1");
        wr(OFS_OWN_SET, 32'h0000_000F); rd_chk(OFS_OWN_STAT, m_own, "R1");
        pads_chk("R1");

        // R2 plane read-back
        wr(OFS_SEL_LO, 32'h1234_5678); rd_chk(OFS_SEL_LO, 32'h1234_5678, "R2");
        wr(OFS_SEL_HI, 32'h9ABC_DEF0); rd_chk(OFS_SEL_HI, 32'h9ABC_DEF0, "R2");

        // R2 R6 routing sweep
        for (int od = 0; od < 2; od++) begin
            if (od == 0) wr(OFS_OD_CLR, '1); else wr(OFS_OD_SET, 32'h5555_5555);
            for (int o = 0; o < 3; o++) begin
                wr(OFS_OWN_SET, own_pats[o]);
                wr(OFS_OWN_CLR, ~own_pats[o]);
                for (int s = 0; s < 5; s++) begin
                    wr(OFS_SEL_LO, lo_pats[s]);
                    wr(OFS_SEL_HI, hi_pats[s]);
                    pads_chk(od == 0 ? "R2" : "R6");
                end
            end
        end
        rd_chk(OFS_OD_STAT, 32'h5555_5555, "R6");

        // R6 GPIO open-drain: driven 1 released, driven 0 pulled
        wr(OFS_OWN_SET, '1); wr(OFS_OE_SET, '1); wr(OFS_OD_SET, '1);
        wr(OFS_DAT_SET, 32'hFFFF_0000); wr(OFS_DAT_CLR, 32'h0000_FFFF);
        #1;
        chk(pad_oe === 32'h0000_FFFF, "R6", "pad_oe od", pad_oe, 32'h0000_FFFF);
        chk(pad_out === 32'hFFFF_0000, "R6", "pad_out od", pad_out, 32'hFFFF_0000);
        @(negedge clk);

        // R5 live pad read, any ownership
        wr(OFS_OWN_CLR, 32'hFF00_FF00);
        pad_in = 32'hDEAD_BEEF; rd_chk(OFS_PAD_STAT, 32'hDEAD_BEEF, "R5");
        pad_in = 32'h0123_4567; rd_chk(OFS_PAD_STAT, 32'h0123_4567, "R5");

        // R7 pulls
        wr(OFS_PD_SET, 32'h0000_00F0);
        rd_chk(OFS_PU_STAT, m_pu, "R7");
        rd_chk(OFS_PD_STAT, m_pd, "R7");
        wr(OFS_PU_CLR, 32'h0F00_0000);
        wr(OFS_PD_CLR, 32'h0000_0030);
        wr(OFS_PU_SET, 32'h0000_0010);
        #1;
        chk(pad_pull_up === m_pu, "R7", "pad_pull_up", pad_pull_up, m_pu);
        chk(pad_pull_dn === m_pd, "R7", "pad_pull_dn", pad_pull_dn, m_pd);
        @(negedge clk);

        // R9 write-only/unmapped reads zero, status/unmapped writes inert
        rd_chk(OFS_DAT_SET, '0, "R9");
        rd_chk(OFS_PD_CLR,  '0, "R9");
        rd_chk(5'd27,       '0, "R9");
        wr(OFS_OWN_STAT, '0);
        wr(OFS_DAT_STAT, '1);
        wr(5'd31, '1);
        rd_chk(OFS_OWN_STAT, m_own, "R9");
        rd_chk(OFS_DAT_STAT, m_dat, "R9");
        rd_chk(OFS_PU_STAT,  m_pu,  "R9");

        // R10 back-to-back set/clear on one bit
        wr(OFS_DAT_SET, 32'h0000_0100); wr(OFS_DAT_CLR, 32'h0000_0100);
        rd_chk(OFS_DAT_STAT, m_dat & ~32'h0000_0100, "R10");
        wr(OFS_DAT_CLR, 32'h0000_0200); wr(OFS_DAT_SET, 32'h0000_0200);
        rd_chk(OFS_DAT_STAT, m_dat | 32'h0000_0200, "R10");
        repeat (4) @(negedge clk);
        rd_chk(OFS_DAT_STAT, m_dat, "R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule